// File: doc/BRIEF.md
# Event Fragment Framer

The framer takes one event as a stream of 32-bit payload words and sends it out as one or more fragments. Each fragment starts with two transport header words. Header word 0 carries the device identifier and the fragment length. Header word 1 carries the packet number and the byte offset of the fragment inside the event. The first fragment of an event also carries four preamble words in front of the event data: the device serial, the event number, and the 64-bit event timestamp. Later fragments carry event data straight after their header.

The length field must be known before the header goes out. The block therefore collects each fragment's data words in a local store, up to a configured maximum. It sends the fragment once the store is full or the event's final word has arrived. Metadata is sampled when the first data word of an event is accepted. The output side is a valid/ready word stream with an end-of-fragment marker.

Top module: `evt_frag_framer`

## Requirements
- R1: Header word 0 is {device ID in 31:24, flags 23:18 = 0, subtype 17:16 = 0, length 15:0}. The length is 4*(N-2) bytes, where N is the fragment's total word count including both header words.
- R2: Header word 1 is {packet number in 31:16, byte offset in 15:0}.
- R3: In the first fragment of an event, words 2 to 5 are, in this order: the serial; {8'h00, 24-bit event number}; timestamp bits 63:32; timestamp bits 31:0. Event data starts at word 6. The metadata is the value at the port when the event's first data word is accepted.
- R4: In every later fragment of the same event, event data starts at word 2, in input order.
- R5: A fragment carries at most cfg_max_pay payload words, with the preamble counted as payload. cfg_max_pay must lie in 5..DEPTH and be held stable during an event. A fragment closes when it is full or when the word with in_last has been stored. out_last is high on the final word of every fragment and on no other word.
- R6: The byte offset is 0 for the first fragment. For each later fragment it equals the payload bytes sent earlier in the same event, preamble included.
- R7: The packet number is 0 after reset. It rises by one after each event, and all fragments of one event carry the same value.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values. No input word is lost or repeated.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_max_pay | input | $clog2(DEPTH+1) | Maximum payload words per fragment |
| meta_dev_id | input | 8 | Device identifier |
| meta_serial | input | 32 | Device serial number |
| meta_evt_num | input | 24 | Event number |
| meta_tstamp | input | 64 | Event timestamp |
| in_data | input | 32 | Event data word |
| in_valid | input | 1 | Event data word is valid |
| in_last | input | 1 | Final data word of the event |
| in_ready | output | 1 | Framer accepts a data word |
| out_data | output | 32 | Fragment word |
| out_valid | output | 1 | Fragment word is valid |
| out_last | output | 1 | Final word of a fragment |
| out_ready | input | 1 | Downstream accepts a word |

## Verification
The assertions check on every cycle that:
- the output holds steady under backpressure;
- no fragment exceeds the configured size;
- the store never takes a word beyond its fragment capacity;
- the offset grows by exactly the length of each closed non-final fragment;
- the packet number steps by one at each event end, with the offset cleared.

Only the bench's sweeps can show that the whole word sequence is right. This covers header field placement, preamble order, data order across fragment borders, and where the end-of-fragment marks fall. The bench checks this for every event length from 1 to 20 words against every legal fragment size of a small configuration.

// File: rtl/evt_frag_pkg.sv
package evt_frag_pkg;
   typedef enum logic {ST_FILL, ST_SEND} frag_state_e;
   localparam int HDR_WORDS = 2;
   localparam int PRE_WORDS = 4;
   localparam logic [1:0] SUBTYPE_CODE = 2'd0;
   localparam logic [5:0] FLAGS_CODE   = 6'd0;
endpackage

// File: rtl/frag_word_store.sv
module frag_word_store #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = (32'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
endmodule

// File: rtl/frag_word_mux.sv
module frag_word_mux
   import evt_frag_pkg::*;
#(
   parameter int  IDX_W       = 5,
   parameter bit  TS_HI_FIRST = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             first,
   input  logic [7:0]       dev_id,
   input  logic [15:0]      len_bytes,
   input  logic [15:0]      pkt_num,
   input  logic [15:0]      offset,
   input  logic [31:0]      serial,
   input  logic [23:0]      evt_num,
   input  logic [63:0]      tstamp,
   input  logic [31:0]      data_word,
   output logic [31:0]      word
);
   logic [31:0] ts_a, ts_b;

   generate
      if (TS_HI_FIRST) begin : g_ts_hi
         assign ts_a = tstamp[63:32];
         assign ts_b = tstamp[31:0];
      end else begin : g_ts_lo
         assign ts_a = tstamp[31:0];
         assign ts_b = tstamp[63:32];
      end
   endgenerate

   always_comb begin
      word = data_word;
      if (idx == IDX_W'(0))
         word = {dev_id, FLAGS_CODE, SUBTYPE_CODE, len_bytes};
      else if (idx == IDX_W'(1))
         word = {pkt_num, offset};
      else if (first) begin
         case (idx)
            IDX_W'(2): word = serial;
            IDX_W'(3): word = {8'h00, evt_num};
            IDX_W'(4): word = ts_a;
            IDX_W'(5): word = ts_b;
            default:   word = data_word;
         endcase
      end
   end
endmodule

// File: rtl/evt_frag_framer.sv
module evt_frag_framer
   import evt_frag_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter bit TS_HI_FIRST = 1'b1,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH + HDR_WORDS),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_max_pay,
   input  logic [7:0]       meta_dev_id,
   input  logic [31:0]      meta_serial,
   input  logic [23:0]      meta_evt_num,
   input  logic [63:0]      meta_tstamp,
   input  logic [31:0]      in_data,
   input  logic             in_valid,
   input  logic             in_last,
   output logic             in_ready,
   output logic [31:0]      out_data,
   output logic             out_valid,
   output logic             out_last,
   input  logic             out_ready
);
   generate
      if (DEPTH < PRE_WORDS + 1) begin : g_bad_depth
         $error("evt_frag_framer: DEPTH must be at least 5");
      end
   endgenerate

   frag_state_e      st_q;
   logic [CNT_W-1:0] dcnt_q;
   logic [IDX_W-1:0] idx_q;
   logic             first_q, ev_end_q;
   logic [15:0]      pkt_q, off_q;
   logic [7:0]       dev_q;
   logic [31:0]      serial_q;
   logic [23:0]      evt_q;
   logic [63:0]      ts_q;

   logic             in_fire, out_fire;
   logic [CNT_W-1:0] cap;
   logic [IDX_W-1:0] pay_words, last_idx, rd_idx;
   logic [15:0]      len_b;
   logic [31:0]      rd_data;

   assign in_ready  = (st_q == ST_FILL);
   assign out_valid = (st_q == ST_SEND);
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;

   assign cap       = first_q ? (cfg_max_pay - CNT_W'(PRE_WORDS)) : cfg_max_pay;
   assign pay_words = (first_q ? IDX_W'(PRE_WORDS) : IDX_W'(0)) + IDX_W'(dcnt_q);
   assign last_idx  = pay_words + IDX_W'(1);
   assign len_b     = 16'(pay_words) << 2;
   assign rd_idx    = idx_q - (first_q ? IDX_W'(HDR_WORDS + PRE_WORDS) : IDX_W'(HDR_WORDS));
   assign out_last  = out_valid && (idx_q == last_idx);

   frag_word_store #(.DEPTH(DEPTH), .WIDTH(32)) u_store (
      .clk     (clk),
      .wr_en   (in_fire),
      .wr_addr (AW'(dcnt_q)),
      .wr_data (in_data),
      .rd_addr (AW'(rd_idx)),
      .rd_data (rd_data)
   );

   frag_word_mux #(.IDX_W(IDX_W), .TS_HI_FIRST(TS_HI_FIRST)) u_mux (
      .idx       (idx_q),
      .first     (first_q),
      .dev_id    (dev_q),
      .len_bytes (len_b),
      .pkt_num   (pkt_q),
      .offset    (off_q),
      .serial    (serial_q),
      .evt_num   (evt_q),
      .tstamp    (ts_q),
      .data_word (rd_data),
      .word      (out_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_FILL;
         dcnt_q   <= '0;
         idx_q    <= '0;
         first_q  <= 1'b1;
         ev_end_q <= 1'b0;
         pkt_q    <= '0;
         off_q    <= '0;
         dev_q    <= '0;
         serial_q <= '0;
         evt_q    <= '0;
         ts_q     <= '0;
      end else begin
         case (st_q)
            ST_FILL: begin
               if (in_fire) begin
                  dcnt_q <= dcnt_q + CNT_W'(1);
                  if (first_q && dcnt_q == '0) begin
                     dev_q    <= meta_dev_id;
                     serial_q <= meta_serial;
                     evt_q    <= meta_evt_num;
                     ts_q     <= meta_tstamp;
                  end
                  if (in_last || (dcnt_q + CNT_W'(1) == cap)) begin
                     st_q     <= ST_SEND;
                     ev_end_q <= in_last;
                  end
               end
            end
            default: begin
               if (out_fire) begin
                  if (idx_q == last_idx) begin
                     st_q   <= ST_FILL;
                     idx_q  <= '0;
                     dcnt_q <= '0;
                     if (ev_end_q) begin
                        first_q <= 1'b1;
                        pkt_q   <= pkt_q + 16'd1;
                        off_q   <= '0;
                     end else begin
                        first_q <= 1'b0;
                        off_q   <= off_q + len_b;
                     end
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
         endcase
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   // R5
   cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (32'(cfg_max_pay) >= PRE_WORDS + 1) && (32'(cfg_max_pay) <= DEPTH));

   // R5
   frag_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> 32'(pay_words) <= 32'(cfg_max_pay));

   // R8
   no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire |-> dcnt_q < cap);

   // R6
   offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last && !ev_end_q |=> off_q == $past(off_q) + $past(len_b));

   // R7
   pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_last && ev_end_q |=> pkt_q == $past(pkt_q) + 16'd1 && off_q == 16'd0);
endmodule

// File: tb/tb_evt_frag_framer.sv
module tb_evt_frag_framer;
   localparam int DEPTH = 8;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] cfg_max_pay = CNT_W'(5);
   logic [7:0]       meta_dev_id = '0;
   logic [31:0]      meta_serial = '0;
   logic [23:0]      meta_evt_num = '0;
   logic [63:0]      meta_tstamp = '0;
   logic [31:0]      in_data = '0;
   logic             in_valid = 1'b0, in_last = 1'b0;
   logic             in_ready;
   logic [31:0]      out_data;
   logic             out_valid, out_last;
   logic             out_ready = 1'b0;

   always #2 clk = ~clk;

   evt_frag_framer #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_max_pay(cfg_max_pay),
      .meta_dev_id(meta_dev_id), .meta_serial(meta_serial),
      .meta_evt_num(meta_evt_num), .meta_tstamp(meta_tstamp),
      .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
   );

   int checks = 0, errors = 0, cyc = 0;
   bit abort = 0;
   int pkt = 0;
   logic [31:0] exp_w[$];
   logic        exp_l[$];
   string       exp_t[$];

   function automatic logic [31:0] dword(int ev, int i);
      return {16'(ev), 16'(i)} ^ 32'h5A3C_0000;
   endfunction

   task automatic push(logic [31:0] w, logic l, string t);
      exp_w.push_back(w); exp_l.push_back(l); exp_t.push_back(t);
   endtask

   task automatic build(int ev, int len, int cap);
      int rem = len, done = 0, off = 0;
      bit first = 1;
      while (rem > 0) begin
         int pre = first ? 4 : 0;
         int room = first ? cap - 4 : cap;
         int d = (rem < room) ? rem : room;
         int pay = pre + d;
         push({meta_dev_id, 6'd0, 2'd0, 16'(4 * pay)}, 1'b0, "R1");
         push({16'(pkt), 16'(off)}, 1'b0, "R2 R6 R7");
         if (first) begin
            push(meta_serial, 1'b0, "R3");
            push({8'h00, meta_evt_num}, 1'b0, "R3");
            push(meta_tstamp[63:32], 1'b0, "R3");
            push(meta_tstamp[31:0], 1'b0, "R3");
         end
         for (int i = 0; i < d; i++)
            push(dword(ev, done + i), (i == d - 1), first ? "R3 R5" : "R4 R5");
         done += d; rem -= d; off += 4 * pay; first = 0;
      end
      pkt++;
   endtask

   task automatic run_event(int ev, int len, int cap);
      int sent = 0;
      bit held = 0;
      logic [31:0] hold_w;
      logic hold_l;
      @(negedge clk);
      cfg_max_pay  = CNT_W'(cap);
      meta_dev_id  = 8'(ev * 3 + 1);
      meta_serial  = 32'h1000_0000 + 32'(ev * 17);
      meta_evt_num = 24'(ev * 5 + 2);
      meta_tstamp  = {32'hABC0_0000 + 32'(ev), 32'(ev * 9 + 7)};
      build(ev, len, cap);
      while ((sent < len || exp_w.size() > 0) && !abort) begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            abort = 1;
         end
         if (held) begin
            checks++;
            if (!out_valid || out_data !== hold_w || out_last !== hold_l) begin
               errors++;
               $display("FAIL R8: held word changed, actual %h/%b expected %h/%b", out_data, out_last, hold_w, hold_l);
            end
         end
         in_valid  = (sent < len) && ((cyc % 4) != 3);
         in_data   = dword(ev, sent);
         in_last   = (sent == len - 1);
         out_ready = (((cyc * 3) + cap) % 7) > 1;
         if (in_valid && in_ready) sent++;
         held = out_valid && !out_ready;
         hold_w = out_data; hold_l = out_last;
         if (out_valid && out_ready) begin
            checks++;
            if (exp_w.size() == 0) begin
               errors++;
               $display("FAIL R8: extra word, actual %h expected none", out_data);
            end else begin
               logic [31:0] w = exp_w.pop_front();
               logic l = exp_l.pop_front();
               string t = exp_t.pop_front();
               if (out_data !== w || out_last !== l) begin
                  errors++;
                  $display("FAIL %s: ev %0d cap %0d, actual %h/%b expected %h/%b", t, ev, cap, out_data, out_last, w, l);
               end
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   initial begin
      int ev = 0;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R9: in reset, actual valid %b ready %b expected 0 1", out_valid, in_ready);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R9: after reset, actual valid %b ready %b expected 0 1", out_valid, in_ready);
      end
      for (int cap = 5; cap <= DEPTH; cap++) begin
         for (int len = 1; len <= 20; len++) begin
            if (!abort) run_event(ev, len, cap);
            ev++;
         end
      end
      checks++;
      if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R8: idle at end, actual ready %b valid %b expected 1 0", in_ready, out_valid);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule